// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block gathers interrupt requests from a parameterised set of maskable sources, plus a non-maskable request line and a breakpoint request. It selects one winner and presents it to the processor as a valid flag and a vector number. Each maskable source has an enable bit and a one-bit level. Level 1 sources beat level 0 sources. Within one level, the lowest source index wins. A global mask input from the processor blocks all maskable sources. The non-maskable line and the breakpoint request bypass the mask and outrank every maskable source. The non-maskable line outranks the breakpoint.

The selection is held in a register. The processor raises a boundary strobe when an instruction completes. If a selection is valid in that cycle, the block pulses an accept output and a set-mask output, and the registered vector stays steady for that whole cycle. The non-maskable line is active low and edge-triggered. A falling edge is latched and stays pending until it is accepted. Maskable and breakpoint requests are level-sensitive and are cleared only by the logic that raised them.

Each vector number is turned into a vector address by a base plus a fixed stride.

Top module: `irq_arb_top`

## Requirements
- R1: A maskable source i takes part in arbitration only while both `src_req[i]` and `src_en[i]` are 1.
- R2: While `mask_i` is 1, no maskable source is presented. `req_valid_o` is 0 unless the non-maskable or breakpoint request is pending.
- R3: A participating source with `src_lvl` bit 1 wins over every participating source whose level bit is 0, whatever their indices.
- R4: Among participating sources of the same level, the lowest index wins.
- R5: Priority order is: non-maskable first, breakpoint second, then all maskable sources. Both of the first two are presented even while `mask_i` is 1.
- R6: `accept_o` and `set_mask_o` go high only in a cycle where `boundary_i` is 1 and `req_valid_o` is 1. In that cycle `vec_o` shows the accepted vector. The accepted source is not re-presented in the next cycle unless it is still requesting with the mask clear.
- R7: A maskable request blocked by the mask is not lost. It is presented one cycle after `mask_i` returns to 0.
- R8: A falling edge on `nmi_n` becomes visible on `vec_o` two clock edges later. It stays pending until accepted and is cleared by that acceptance.
- R9: Vector numbers are assigned as follows: non-maskable = 0, breakpoint = 1, source i = i+2. `vec_addr_o` = `VEC_BASE` + `vec_o`·`VEC_STRIDE`, with defaults 0x0040 and 4.
- R10: After reset, `req_valid_o`, `accept_o` and `set_mask_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Level request per maskable source |
| src_en | input | N_SRC | Enable per maskable source |
| src_lvl | input | N_SRC | Level bit per source (1 = high) |
| mask_i | input | 1 | Global mask from the processor |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge |
| brk_req | input | 1 | Breakpoint request, level, unmaskable |
| boundary_i | input | 1 | Instruction-completion strobe |
| req_valid_o | output | 1 | A selection is pending |
| vec_o | output | VEC_W | Registered vector number of the selection |
| vec_addr_o | output | ADDR_W | Vector address derived from vec_o |
| accept_o | output | 1 | Acceptance pulse |
| set_mask_o | output | 1 | Tells the processor to set its mask |

## Verification
The table drives request words that separate enable gating from level order. Some words put a high-index level-1 source against low-index level-0 sources. Others leave a low-index source enabled only in part, so that a wrong gate or a reversed scan picks a different index. Directed cases then do the following:
- Hold the mask while requests wait, to tell blocking apart from loss.
- Raise a non-maskable edge on top of a breakpoint, to check their order and the latch's lifetime across acceptance.
- Toggle the boundary strobe, to show that acceptance needs both the strobe and a valid selection.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NMI_VEC     = 0;
  localparam int BRK_VEC     = 1;
  localparam int SRC_VEC_OFS = 2;

  function automatic int vec_width(input int n_src);
    return $clog2(n_src + SRC_VEC_OFS);
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
// Lowest-index-first priority encoder.
module irq_prio_enc #(
  parameter int W     = 16,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_nmi_latch.sv
// Falling-edge detector with a sticky pending flag; a new edge wins over a clear.
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      if (fall)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int VEC_W      = 5,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 4
) (
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  assign addr = ADDR_W'(VEC_BASE) + ADDR_W'(vec) * ADDR_W'(VEC_STRIDE);
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int N_SRC      = 16,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 4,
  parameter int VEC_W      = vec_width(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic [N_SRC-1:0]  src_en,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              mask_i,
  input  logic              nmi_n,
  input  logic              brk_req,
  input  logic              boundary_i,
  output logic              req_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              accept_o,
  output logic              set_mask_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int N_LVL = 2;

  logic             nmi_pend;
  logic             nmi_clr;
  logic             eff_mask;
  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] lvl_req [N_LVL];
  logic             lvl_hit [N_LVL];
  logic [IDX_W-1:0] lvl_idx [N_LVL];
  logic             nmi_live, brk_live;
  logic             nxt_valid;
  logic [VEC_W-1:0] nxt_vec;
  logic             sel_valid_q;
  logic [VEC_W-1:0] sel_vec_q;

  // Acceptance happens from the registered selection.
  assign accept_o   = boundary_i & sel_valid_q;
  assign set_mask_o = accept_o;
  assign nmi_clr    = accept_o && (sel_vec_q == VEC_W'(NMI_VEC));

  irq_nmi_latch u_nmi (
    .clk  (clk),
    .rst  (rst),
    .nmi_n(nmi_n),
    .clr  (nmi_clr),
    .pend (nmi_pend)
  );

  // The mask is treated as set in the accept cycle, so the next selection
  // already reflects the processor's updated mask.
  assign eff_mask = mask_i | accept_o;
  assign live     = eff_mask ? '0 : (src_req & src_en);
  assign lvl_req[0] = live & ~src_lvl;
  assign lvl_req[1] = live &  src_lvl;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    irq_prio_enc #(.W(N_SRC), .IDX_W(IDX_W)) u_enc (
      .req(lvl_req[g]),
      .hit(lvl_hit[g]),
      .idx(lvl_idx[g])
    );
  end

  assign nmi_live = nmi_pend & ~nmi_clr;
  assign brk_live = brk_req & ~(accept_o && (sel_vec_q == VEC_W'(BRK_VEC)));

  always_comb begin
    nxt_valid = 1'b1;
    nxt_vec   = '0;
    if (nmi_live)
      nxt_vec = VEC_W'(NMI_VEC);
    else if (brk_live)
      nxt_vec = VEC_W'(BRK_VEC);
    else if (lvl_hit[1])
      nxt_vec = VEC_W'(lvl_idx[1]) + VEC_W'(SRC_VEC_OFS);
    else if (lvl_hit[0])
      nxt_vec = VEC_W'(lvl_idx[0]) + VEC_W'(SRC_VEC_OFS);
    else
      nxt_valid = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid_q <= 1'b0;
      sel_vec_q   <= '0;
    end else begin
      sel_valid_q <= nxt_valid;
      sel_vec_q   <= nxt_vec;
    end
  end

  assign req_valid_o = sel_valid_q;
  assign vec_o       = sel_vec_q;

  irq_vec_addr #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_addr (
    .vec (sel_vec_q),
    .addr(vec_addr_o)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mask_i,
  input logic             boundary_i,
  input logic             req_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             accept_o,
  input logic             set_mask_o
);
  p_accept_gated_r6: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (boundary_i && req_valid_o));

  p_setmask_with_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (set_mask_o == accept_o));

  p_masked_only_unmaskable_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_i) && req_valid_o) |-> (vec_o <= VEC_W'(1)));

  p_nmi_held_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && vec_o == '0 && !accept_o) |=> (req_valid_o && vec_o == '0));

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> !req_valid_o);
endmodule

bind irq_arb_top irq_arb_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .mask_i(mask_i), .boundary_i(boundary_i),
  .req_valid_o(req_valid_o), .vec_o(vec_o), .accept_o(accept_o),
  .set_mask_o(set_mask_o)
);

// File: tb/tb_irq_arb_top.sv
module tb_irq_arb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] src_req = '0, src_en = '0, src_lvl = '0;
  logic        mask_i = 0, nmi_n = 1, brk_req = 0, boundary_i = 0;
  logic        req_valid_o, accept_o, set_mask_o;
  logic [4:0]  vec_o;
  logic [15:0] vec_addr_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_arb_top dut (.*);

  typedef struct packed {
    logic [15:0] req;
    logic [15:0] en;
    logic [15:0] lvl;
    logic        mask;
    logic        ev;
    logic [4:0]  evec;
  } row_t;

  localparam row_t TBL [7] = '{
    '{16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 5'd0},  // R1 nothing
    '{16'h0030, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 5'd6},  // R4 src4
    '{16'h0030, 16'hFFEF, 16'h0000, 1'b0, 1'b1, 5'd7},  // R1 src4 disabled
    '{16'h8031, 16'hFFFF, 16'h8000, 1'b0, 1'b1, 5'd17}, // R3 src15 high
    '{16'h0031, 16'hFFFF, 16'h0030, 1'b0, 1'b1, 5'd6},  // R3 R4 src4
    '{16'h0031, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 5'd0},  // R2 masked
    '{16'h0100, 16'h00FF, 16'h0100, 1'b0, 1'b0, 5'd0}   // R1 not enabled
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid", req_valid_o, 0);
    chk("R10 accept", accept_o, 0);
    rst = 0;
    step();
    chk("R10 valid after release", req_valid_o, 0);
    chk("R10 set_mask", set_mask_o, 0);

    for (int i = 0; i < 7; i++) begin
      src_req = TBL[i].req; src_en = TBL[i].en; src_lvl = TBL[i].lvl;
      mask_i = TBL[i].mask;
      step();
      chk($sformatf("R1-table row%0d valid", i), req_valid_o, TBL[i].ev);
      if (TBL[i].ev) chk($sformatf("R3/R4 table row%0d vec", i), vec_o, TBL[i].evec);
    end

    // R9 address for vector 6
    src_req = 16'h0010; src_en = 16'hFFFF; src_lvl = '0; mask_i = 0;
    step();
    chk("R9 vec", vec_o, 6);
    chk("R9 addr", vec_addr_o, 'h40 + 6 * 4);

    // R6 no boundary -> no accept
    chk("R6 no boundary", accept_o, 0);
    boundary_i = 1; #1;
    chk("R6 accept", accept_o, 1);
    chk("R6 set_mask", set_mask_o, 1);
    chk("R6 vec at accept", vec_o, 6);
    @(posedge clk); @(negedge clk);
    boundary_i = 0; mask_i = 1;
    chk("R6 not re-presented", req_valid_o, 0);
    #1 chk("R6 no accept without valid", accept_o, 0);

    // R7 blocked request survives the mask
    src_req = 16'h0004;
    step();
    chk("R7 blocked", req_valid_o, 0);
    mask_i = 0;
    step();
    chk("R7 presented after unmask", vec_o, 4);
    chk("R7 valid after unmask", req_valid_o, 1);

    // R5 breakpoint bypasses mask
    mask_i = 1; brk_req = 1;
    step();
    chk("R5 brk under mask", vec_o, 1);
    chk("R5 brk valid", req_valid_o, 1);

    // R8 NMI edge, two edges to visibility, beats breakpoint
    nmi_n = 0;
    step();
    chk("R8 not yet visible", vec_o, 1);
    step();
    chk("R5 R8 nmi wins", vec_o, 0);
    step();
    chk("R8 held pending", vec_o, 0);
    boundary_i = 1; #1;
    chk("R8 accepted", accept_o, 1);
    @(posedge clk); @(negedge clk);
    boundary_i = 0;
    chk("R8 cleared by accept", vec_o, 1);
    nmi_n = 1;
    step();
    chk("R8 no new nmi on rise", vec_o, 1);
    brk_req = 0;
    step();
    chk("R2 all quiet under mask", req_valid_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule